// File: doc/BRIEF.md
# AES Closing-Round Datapath with Wide Vector Write-Back

This block computes the final round of an AES encryption on one 128-bit state using one 128-bit round key. The state bytes are first permuted by row rotation, then every byte goes through the forward AES substitution, and the result is XORed with the round key. The column-mixing step of the middle rounds is absent. The 128-bit result is written into the low lane of a vector destination that is wider than 128 bits.

A single write-back select picks one of two behaviours. The first is a two-operand, merge style: the state is read from the low lane of the old destination, and the bits above 127 keep their old values. The second is a three-operand, clearing style: the state comes from a separate source port, and the bits above 127 become zero. The result is registered, so it appears one clock after the operands are presented. The operation raises no arithmetic flags, so the block has no flag outputs.

Top module: `aes_last_round_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `dest_out` becomes all zeros after that edge.
- R2: Byte k of any 128-bit value is bits 8k+7..8k. Byte k sits in row k mod 4 and column k div 4. Before substitution, output byte (row r, column c) takes the input byte at row r, column (c+r) mod 4, so row 0 is unchanged and rows 1, 2 and 3 rotate left by 1, 2 and 3 byte positions.
- R3: Every byte is replaced by the standard AES forward S-box value. Examples: 0x00 becomes 0x63, 0x53 becomes 0xED and 0x01 becomes 0x7C. The low lane of `dest_out` is the substituted state XOR `round_key`.
- R4: When `wb_clear` is 0, the state is `dest_old[127:0]` and `src_state` has no effect on `dest_out`.
- R5: When `wb_clear` is 0, `dest_out[VEC_W-1:128]` equals the `dest_old[VEC_W-1:128]` presented with the operands.
- R6: When `wb_clear` is 1, the state is `src_state` and `dest_old` has no effect on `dest_out`.
- R7: When `wb_clear` is 1, `dest_out[VEC_W-1:128]` is zero.
- R8: The operands sampled at a rising edge out of reset appear on `dest_out` after that same edge, and `dest_out` does not change between edges.
- R9: Take the AES-128 known-answer example with key 2b7e151628aed2a6abf7158809cf4f3c and plaintext 3243f6a8885a308d313198a2e0370734, with byte 0 being the leftmost hex pair. When the state after round nine and the tenth round key are applied, the low lane equals 3925841d02dc09fbdc118597196a0b32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wb_clear | input | 1 | 0: state from old destination, upper lane kept; 1: state from `src_state`, upper lane zeroed |
| src_state | input | 128 | State operand used in three-operand style |
| round_key | input | 128 | Final round key |
| dest_old | input | VEC_W | Prior destination contents |
| dest_out | output | VEC_W | Registered destination after write-back |

## Verification
The assertions assume that every operand is a known value at each rising edge, because a stability or lane property would be meaningless on unknown input. They also assume that `wb_clear` is held for the whole cycle in which it is sampled. The bench meets both assumptions by driving all inputs only on falling edges and by giving every bit a defined value from reset onward, including the wide random upper lanes and the random source that is supposed to be ignored. The random source is kept so that its effect, if any, would be visible.

// File: rtl/aes_last_pkg.sv
// Shared types, widths and the GF(2^8) multiply used by the substitution logic.
// Assumes the AES field polynomial x^8 + x^4 + x^3 + x + 1.
package aes_last_pkg;

    localparam int BYTE_W  = 8;
    localparam int ROWS    = 4;
    localparam int COLS    = 4;
    localparam int NBYTES  = ROWS * COLS;
    localparam int BLOCK_W = NBYTES * BYTE_W;

    typedef logic [BYTE_W-1:0]  byte_t;
    typedef logic [BLOCK_W-1:0] block_t;

    // Product of two field elements by shift-and-add with modular reduction.
    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t cur;
        acc = '0;
        cur = a;
        for (int k = 0; k < BYTE_W; k++) begin
            if (b[k]) acc = acc ^ cur;
            cur = {cur[BYTE_W-2:0], 1'b0} ^ (cur[BYTE_W-1] ? 8'h1b : 8'h00);
        end
        return acc;
    endfunction

    // Field square, written through the general multiply.
    function automatic byte_t gf_sq(input byte_t a);
        return gf_mul(a, a);
    endfunction

endpackage

// File: rtl/aes_sbox_calc.sv
// Forward AES S-box for one byte. It computes the value, with no table:
// first the multiplicative inverse (x^254, where 0 maps to 0), then the
// affine transform with constant 0x63. Purely combinational.
module aes_sbox_calc
    import aes_last_pkg::*;
(
    input  logic [7:0] din,
    output logic [7:0] dout
);

    byte_t p2, p3, p12, p15, p240, p254, inv;

    // Exponent chain: 2, 3, 12, 15, 240, 252, then 254.
    always_comb begin
        p2   = gf_sq(din);
        p3   = gf_mul(p2, din);
        p12  = gf_sq(gf_sq(p3));
        p15  = gf_mul(p12, p3);
        p240 = gf_sq(gf_sq(gf_sq(gf_sq(p15))));
        p254 = gf_mul(gf_mul(p240, p12), p2);
        inv  = p254;
    end

    // Affine step: XOR of the inverse with four left rotations, plus 0x63.
    always_comb begin
        dout = inv
             ^ {inv[6:0], inv[7]}
             ^ {inv[5:0], inv[7:6]}
             ^ {inv[4:0], inv[7:5]}
             ^ {inv[3:0], inv[7:4]}
             ^ 8'h63;
    end

endmodule

// File: rtl/aes_row_shift.sv
// Row rotation of a column-major 4x4 byte state. Byte k sits at row k%4 and
// column k/4. Row r rotates left by r columns. Pure wiring, no logic levels.
module aes_row_shift
    import aes_last_pkg::*;
(
    input  logic [127:0] din,
    output logic [127:0] dout
);

    for (genvar c = 0; c < COLS; c++) begin : g_col
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            localparam int DST = c * ROWS + r;
            localparam int SRC = ((c + r) % COLS) * ROWS + r;
            // Route one source byte to its rotated position.
            assign dout[DST*BYTE_W +: BYTE_W] = din[SRC*BYTE_W +: BYTE_W];
        end
    end

endmodule

// File: rtl/aes_sub_layer.sv
// Applies the forward S-box to all bytes of a 128-bit block in parallel.
// One substitution instance per byte, with no sharing.
module aes_sub_layer
    import aes_last_pkg::*;
(
    input  logic [127:0] din,
    output logic [127:0] dout
);

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        // Substitute byte k.
        aes_sbox_calc u_sbox (
            .din  (din[k*BYTE_W +: BYTE_W]),
            .dout (dout[k*BYTE_W +: BYTE_W])
        );
    end

endmodule

// File: rtl/aes_last_round_unit.sv
// Closing AES encryption round with write-back into a wide vector destination.
// Assumes VEC_W > 128. When wb_clear is 0, the state comes from the old
// destination and the upper lane is merged. When wb_clear is 1, the state
// comes from src_state and the upper lane is zeroed. The output is registered,
// with one cycle of latency.
module aes_last_round_unit
    import aes_last_pkg::*;
#(
    parameter int VEC_W = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wb_clear,
    input  logic [127:0]     src_state,
    input  logic [127:0]     round_key,
    input  logic [VEC_W-1:0] dest_old,
    output logic [VEC_W-1:0] dest_out
);

    localparam int UP_W = VEC_W - BLOCK_W;

    block_t          state_sel;
    block_t          shifted;
    block_t          substituted;
    block_t          low_next;
    logic [UP_W-1:0] up_next;

    // Pick the state operand according to the write-back style.
    always_comb state_sel = wb_clear ? src_state : dest_old[BLOCK_W-1:0];

    aes_row_shift u_shift (
        .din  (state_sel),
        .dout (shifted)
    );

    aes_sub_layer u_sub (
        .din  (shifted),
        .dout (substituted)
    );

    // Add the round key, then pick the upper-lane policy.
    always_comb begin
        low_next = substituted ^ round_key;
        up_next  = wb_clear ? '0 : dest_old[VEC_W-1:BLOCK_W];
    end

    // Destination register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) dest_out <= '0;
        else        dest_out <= {up_next, low_next};
    end

endmodule

// File: rtl/aes_last_round_chk.sv
// Temporal checks for aes_last_round_unit, attached through bind.
// Assumes the operands are known at every rising edge.
module aes_last_round_chk #(
    parameter int VEC_W = 512
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wb_clear,
    input logic [127:0]     src_state,
    input logic [127:0]     round_key,
    input logic [VEC_W-1:0] dest_old,
    input logic [VEC_W-1:0] dest_out
);

    logic primed;

    // Set after the first edge, so that $past always has a real cycle.
    always_ff @(posedge clk) primed <= 1'b1;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> dest_out == '0);

    // R5
    merge_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_clear |=> dest_out[VEC_W-1:128] == $past(dest_old[VEC_W-1:128]));

    // R7
    clear_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_clear |=> dest_out[VEC_W-1:128] == '0);

    // R8 and R4: with unchanged effective operands, the result holds
    holds_on_same_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed === 1'b1 && $past(rst_n) && $stable(wb_clear) && $stable(round_key)
         && $stable(dest_old) && (!wb_clear || $stable(src_state)))
        |=> $stable(dest_out));

    // R6: in clearing mode, changes to dest_old alone leave the result as it is
    clear_ignores_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed === 1'b1 && $past(rst_n) && wb_clear && $past(wb_clear)
         && $stable(src_state) && $stable(round_key))
        |=> $stable(dest_out));

endmodule

bind aes_last_round_unit aes_last_round_chk #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wb_clear  (wb_clear),
    .src_state (src_state),
    .round_key (round_key),
    .dest_old  (dest_old),
    .dest_out  (dest_out)
);

// File: tb/aes_last_round_unit_bench.sv
// Self-checking bench: directed corner cases, a full AES-128 known-answer run
// and seeded random operands, all compared against a separate model.
module aes_last_round_unit_bench;

    localparam int VEC_W = 512;
    localparam int UP_W  = VEC_W - 128;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wb_clear = 1'b0;
    logic [127:0]     src_state = '0;
    logic [127:0]     round_key = '0;
    logic [VEC_W-1:0] dest_old = '0;
    logic [VEC_W-1:0] dest_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] sb [256];

    aes_last_round_unit #(.VEC_W(VEC_W)) u_aes_last_round_unit (
        .clk(clk), .rst_n(rst_n), .wb_clear(wb_clear), .src_state(src_state),
        .round_key(round_key), .dest_old(dest_old), .dest_out(dest_out)
    );

    always #5 clk = ~clk;

    // Field multiply, most significant bit first.
    function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 8'h00;
        for (int k = 7; k >= 0; k--) begin
            r = {r[6:0], 1'b0} ^ (r[7] ? 8'h1b : 8'h00);
            if (b[k]) r = r ^ a;
        end
        return r;
    endfunction

    function automatic logic [127:0] from_hex(input logic [127:0] h);
        logic [127:0] v;
        for (int k = 0; k < 16; k++) v[8*k +: 8] = h[127-8*k -: 8];
        return v;
    endfunction

    function automatic logic [127:0] subst(input logic [127:0] s);
        logic [127:0] v;
        for (int k = 0; k < 16; k++) v[8*k +: 8] = sb[s[8*k +: 8]];
        return v;
    endfunction

    function automatic logic [127:0] rows(input logic [127:0] s);
        logic [127:0] v;
        for (int j = 0; j < 16; j++) v[8*j +: 8] = s[8*(4*(((j/4)+(j%4))%4)+(j%4)) +: 8];
        return v;
    endfunction

    function automatic logic [127:0] mixc(input logic [127:0] s);
        logic [127:0] v;
        for (int c = 0; c < 4; c++) begin
            logic [7:0] a0, a1, a2, a3;
            a0 = s[32*c +: 8]; a1 = s[32*c+8 +: 8]; a2 = s[32*c+16 +: 8]; a3 = s[32*c+24 +: 8];
            v[32*c    +: 8] = fmul(a0,2) ^ fmul(a1,3) ^ a2 ^ a3;
            v[32*c+8  +: 8] = a0 ^ fmul(a1,2) ^ fmul(a2,3) ^ a3;
            v[32*c+16 +: 8] = a0 ^ a1 ^ fmul(a2,2) ^ fmul(a3,3);
            v[32*c+24 +: 8] = fmul(a0,3) ^ a1 ^ a2 ^ fmul(a3,2);
        end
        return v;
    endfunction

    function automatic logic [VEC_W-1:0] model(input logic clr, input logic [127:0] src,
            input logic [127:0] key, input logic [VEC_W-1:0] old);
        logic [127:0] st;
        st = clr ? src : old[127:0];
        return {(clr ? {UP_W{1'b0}} : old[VEC_W-1:128]), subst(rows(st)) ^ key};
    endfunction

    function automatic logic [VEC_W-1:0] rand_wide();
        logic [VEC_W-1:0] v;
        for (int k = 0; k < VEC_W/32; k++) v[32*k +: 32] = $urandom;
        return v;
    endfunction

    task automatic check(input string req, input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive operands on a falling edge and sample on the next falling edge.
    task automatic apply(input logic clr, input logic [127:0] src, input logic [127:0] key,
                         input logic [VEC_W-1:0] old);
        wb_clear = clr; src_state = src; round_key = key; dest_old = old;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [VEC_W-1:0] exp, held;
        logic [127:0] rk [11];
        logic [127:0] s;
        logic [7:0] rc;
        void'($urandom(32'd2024));
        // Independent S-box: inverse by search, then affine by rotations.
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 8'h00;
            logic [7:0] b;
            for (int y = 1; y < 256; y++) if (fmul(x[7:0], y[7:0]) == 8'h01) inv = y[7:0];
            b = inv;
            for (int r = 1; r < 5; r++) b = b ^ ((inv << r) | (inv >> (8 - r)));
            sb[x] = b ^ 8'h63;
        end

        @(negedge clk);
        dest_old = rand_wide(); src_state = dest_old[127:0]; round_key = dest_old[255:128];
        @(posedge clk); @(negedge clk);
        check("R1 reset", dest_out, '0);
        rst_n = 1'b1;

        // R3: all-zero state and key give 0x63 in every byte
        apply(1'b1, '0, '0, rand_wide());
        check("R3 sbox 00", dest_out, {{UP_W{1'b0}}, {16{8'h63}}});
        apply(1'b1, {16{8'h53}}, '0, '0);
        check("R3 sbox 53", dest_out, {{UP_W{1'b0}}, {16{8'hed}}});
        apply(1'b1, {16{8'h01}}, {16{8'hff}}, '0);
        check("R3 sbox 01 with key", dest_out, {{UP_W{1'b0}}, {16{8'h83}}});

        // R2: byte k = k, so output byte 1 comes from input byte 5 (0x05 -> 0x6b)
        begin
            logic [127:0] ramp;
            for (int k = 0; k < 16; k++) ramp[8*k +: 8] = k[7:0];
            apply(1'b1, ramp, '0, '0);
            check("R2 rotation ramp", dest_out, model(1'b1, ramp, '0, '0));
            check("R2 byte1", {{(VEC_W-8){1'b0}}, dest_out[15:8]}, {{(VEC_W-8){1'b0}}, 8'h6b});
        end

        // R8: inputs change, output holds until the next edge
        held = dest_out;
        wb_clear = 1'b0; dest_old = rand_wide(); src_state = rand_wide(); round_key = rand_wide();
        #1;
        check("R8 holds before edge", dest_out, held);
        exp = model(1'b0, src_state, round_key, dest_old);
        @(posedge clk); @(negedge clk);
        check("R8 one cycle", dest_out, exp);

        // R4: merge style ignores src_state
        held = dest_out;
        src_state = ~src_state;
        @(posedge clk); @(negedge clk);
        check("R4 src ignored", dest_out, held);

        // R6: clearing style ignores dest_old
        apply(1'b1, rand_wide(), rand_wide(), rand_wide());
        held = dest_out;
        dest_old = ~dest_old;
        @(posedge clk); @(negedge clk);
        check("R6 old ignored", dest_out, held);

        // R9: full AES-128 known answer, the final round done by the design
        rk[0] = from_hex(128'h2b7e151628aed2a6abf7158809cf4f3c);
        rc = 8'h01;
        for (int i = 1; i < 11; i++) begin
            logic [31:0] t;
            t = rk[i-1][127:96];
            t = {t[7:0], t[31:8]};
            t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]} ^ {24'h0, rc};
            rk[i][31:0]   = rk[i-1][31:0]   ^ t;
            rk[i][63:32]  = rk[i-1][63:32]  ^ rk[i][31:0];
            rk[i][95:64]  = rk[i-1][95:64]  ^ rk[i][63:32];
            rk[i][127:96] = rk[i-1][127:96] ^ rk[i][95:64];
            rc = fmul(rc, 8'h02);
        end
        s = from_hex(128'h3243f6a8885a308d313198a2e0370734) ^ rk[0];
        for (int i = 1; i < 10; i++) s = mixc(rows(subst(s))) ^ rk[i];
        apply(1'b1, s, rk[10], rand_wide());
        check("R9 known answer clear", dest_out,
              {{UP_W{1'b0}}, from_hex(128'h3925841d02dc09fbdc118597196a0b32)});
        held = rand_wide();
        held[127:0] = s;
        apply(1'b0, rand_wide(), rk[10], held);
        check("R9 known answer merge", dest_out,
              {held[VEC_W-1:128], from_hex(128'h3925841d02dc09fbdc118597196a0b32)});

        // R5 and R7: random operands in both write-back styles
        for (int n = 0; n < 300; n++) begin
            logic clr = $urandom_range(0, 1) == 1;
            logic [VEC_W-1:0] o = rand_wide();
            logic [127:0] sr = rand_wide();
            logic [127:0] ky = rand_wide();
            apply(clr, sr, ky, o);
            check(clr ? "R7 random clear" : "R5 random merge", dest_out, model(clr, sr, ky, o));
        end

        // R1: reset clears a nonzero result
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 reset after use", dest_out, '0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule